// File: doc/BRIEF.md
# Serial Register Slave with Idle Resync

This block is the host-facing serial port of a sensor-style peripheral. A host drives a serial clock and one data line; every transaction is sixteen clock periods long. The first bit picks the direction, the next seven bits carry a register address, and the last eight bits carry data. On a write the slave takes the data byte in. On a read the slave drives the data byte back on its own output, with an output-enable that a pad outside this block uses to turn the line around. Both serial inputs pass through a two-flop synchroniser into the system clock domain before any edge is detected.

The register file holds a read-only identity byte, a configuration register and a small bank of scratch registers. Setting the top bit of the configuration register starts a soft reset of the digital logic. That bit clears itself one cycle later, and the low seven bits of the same write are kept. A power-on reset and a soft reset share the same aftermath. The serial port stays deaf until its idle timer has expired once, and a settle flag stays low for a fixed number of frame periods. The same idle timer lets the host recover byte alignment after a broken transfer: if the serial clock stops for long enough, the bit counter returns to the start of an address.

Data moves over the serial wires only. The internal write path has no back-pressure: the register file accepts every completed write in the cycle it arrives. Control and status pins are plain levels or pulses.

Top module: `sersync_slave`

## Requirements
- R1: Bits are sampled on rising serial clock edges. The first bit of a transaction is the direction (1 = write, 0 = read), then a 7-bit address MSB first, then 8 data bits MSB first. After sixteen bits the next bit starts a new transaction.
- R2: A write changes the addressed register only after its eighth data bit. The scratch registers at 0x42 up to 0x42+NUM_SCR-1 and the configuration register at 0x41 read back the last value written.
- R3: During a read, sdio_o carries the data MSB first, with each bit driven after a falling serial clock edge of the data phase. sdio_oe is high only during those eight data bits and is low during the address bits and during writes.
- R4: The identity register at 0x00 reads ID_VALUE and ignores writes. Every other address outside 0x41 and the scratch range reads 0x00, and writes to it change no register.
- R5: A configuration write with bit 7 set resets all scratch registers to 0x00. Bits 6:0 of that same write stay in the configuration register.
- R6: Bit 7 of cfg_o is high for exactly one system clock after such a write, and soft_rst_o pulses for that one cycle. A configuration write with bit 7 clear causes no pulse.
- R7: When the serial clock shows no edge for TIMEOUT_CLKS system clocks, the bit counter returns to the start-of-address state. A shorter pause inside a transaction leaves it intact.
- R8: After a power-on reset or a soft reset, the port ignores serial clock edges and never drives sdio_oe until the idle timer has expired once.
- R9: settled_o is low after any reset and rises exactly SETTLE_FRAMES*FRAME_CLKS system clocks after the reset ends, then stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sclk_i | input | 1 | Host serial clock, idles high |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Serial read data toward the pad |
| sdio_oe | output | 1 | High while the slave drives the data line |
| cfg_o | output | 8 | Configuration register contents |
| soft_rst_o | output | 1 | One-cycle pulse when a soft reset is taken |
| settled_o | output | 1 | High once the post-reset settle time has passed |

## Verification
A sweep reads all 128 addresses, which separates the identity, configuration, scratch and unmapped decode regions. A second full read sweep, run after writes to unmapped addresses and to the identity byte, would show any write that aliased into a real register. All 256 data values are written to the rotating scratch registers and read back. This checks every bit position of both shift directions and the MSB-first ordering. Stray clock pulses, a short pause inside a transaction, and a misaligned write followed by an idle gap together show that the timer realigns the stream and that a short pause does not. A soft-reset write with low bits set, a read issued before the timer expires, and a second power-on tell apart the kept configuration bits, the cleared scratch registers, the disarmed port and the settle timing.

// File: rtl/sersync_pkg.sv
package sersync_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int XFER_BITS = 1 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(XFER_BITS);

  localparam logic [ADDR_W-1:0] ID_ADDR  = 7'h00;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 7'h41;
  localparam logic [ADDR_W-1:0] SCR_BASE = 7'h42;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/sersync_sync.sv
module sersync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdio_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdio_s
);
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] sd_pipe;
  logic              sck_last;

  // serial clock idles high, so the pipe resets high to avoid a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '1;
      sd_pipe  <= '0;
      sck_last <= 1'b1;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-2:0], sclk_i};
      sd_pipe  <= {sd_pipe[STAGES-2:0], sdio_i};
      sck_last <= sck_pipe[STAGES-1];
    end
  end

  assign sclk_rise = sck_pipe[STAGES-1] & ~sck_last;
  assign sclk_fall = ~sck_pipe[STAGES-1] & sck_last;
  assign sdio_s    = sd_pipe[STAGES-1];
endmodule

// File: rtl/sersync_shifter.sv
module sersync_shifter
  import sersync_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdio_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  output wr_req_t           wr_req,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              armed,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam int IW = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(TIMEOUT_CLKS - 1);
  localparam logic [IW-1:0] IDLE_SAT  = IW'(TIMEOUT_CLKS);
  localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_BIT      = CNT_W'(XFER_BITS - 1);

  logic [IW-1:0]     idle_cnt;
  logic              dir_wr;
  logic [6:0]        sr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] tx_sr;
  logic              any_edge;
  logic              timeout;
  logic              in_data;

  assign any_edge = sclk_rise | sclk_fall;
  assign timeout  = !any_edge && (idle_cnt == IDLE_LAST);
  assign in_data  = bit_cnt > LAST_ADDR_BIT;
  // address is complete when the bit at LAST_ADDR_BIT arrives
  assign rd_addr  = {sr[5:0], sdio_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      armed    <= 1'b0;
      bit_cnt  <= '0;
      dir_wr   <= 1'b0;
      sr       <= '0;
      addr_q   <= '0;
      tx_sr    <= '0;
      wr_valid <= 1'b0;
      wr_req   <= '0;
      sdio_o   <= 1'b0;
      sdio_oe  <= 1'b0;
    end else if (soft_rst) begin
      idle_cnt <= '0;
      armed    <= 1'b0;
      bit_cnt  <= '0;
      dir_wr   <= 1'b0;
      sr       <= '0;
      addr_q   <= '0;
      tx_sr    <= '0;
      wr_valid <= 1'b0;
      wr_req   <= '0;
      sdio_o   <= 1'b0;
      sdio_oe  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (any_edge) begin
        idle_cnt <= '0;
      end else if (idle_cnt != IDLE_SAT) begin
        idle_cnt <= idle_cnt + 1'b1;
      end

      if (timeout) begin
        bit_cnt <= '0;
        armed   <= 1'b1;
        sdio_oe <= 1'b0;
      end else if (armed && sclk_rise) begin
        sr      <= {sr[5:0], sdio_s};
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == '0) begin
          dir_wr <= sdio_s;
        end
        if (bit_cnt == LAST_ADDR_BIT) begin
          addr_q <= rd_addr;
          if (!dir_wr) begin
            tx_sr <= rd_data;
          end
        end
        if (bit_cnt == LAST_BIT) begin
          sdio_oe <= 1'b0;
          if (dir_wr) begin
            wr_valid     <= 1'b1;
            wr_req.addr  <= addr_q;
            wr_req.data  <= {sr, sdio_s};
          end
        end
      end else if (armed && sclk_fall && in_data && !dir_wr) begin
        sdio_oe <= 1'b1;
        sdio_o  <= tx_sr[DATA_W-1];
        tx_sr   <= {tx_sr[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sersync_regfile.sv
module sersync_regfile
  import sersync_pkg::*;
#(
  parameter int                NUM_SCR   = 4,
  parameter logic [DATA_W-1:0] ID_VALUE  = 8'h5A,
  parameter logic [DATA_W-1:0] CFG_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  wr_req_t           wr_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] cfg_o,
  output logic              soft_rst
);
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] scr_q [NUM_SCR];

  // the top config bit is itself the soft reset strobe; it drops next cycle
  assign soft_rst = cfg_q[DATA_W-1];
  assign cfg_o    = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (soft_rst) begin
      cfg_q[DATA_W-1] <= 1'b0;
    end else if (wr_valid && wr_req.addr == CFG_ADDR) begin
      cfg_q <= wr_req.data;
    end
  end

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (soft_rst) begin
        r <= '0;
      end else if (wr_valid && wr_req.addr == SCR_BASE + ADDR_W'(g)) begin
        r <= wr_req.data;
      end
    end
    assign scr_q[g] = r;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ID_ADDR) begin
      rd_data = ID_VALUE;
    end else if (rd_addr == CFG_ADDR) begin
      rd_data = cfg_q;
    end
    for (int i = 0; i < NUM_SCR; i++) begin
      if (rd_addr == SCR_BASE + ADDR_W'(i)) begin
        rd_data = scr_q[i];
      end
    end
  end
endmodule

// File: rtl/sersync_settle.sv
module sersync_settle #(
  parameter int FRAME_CLKS    = 4000,
  parameter int SETTLE_FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  output logic settled
);
  localparam int FW = $clog2(FRAME_CLKS + 1);
  localparam int NW = $clog2(SETTLE_FRAMES + 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_CLKS - 1);
  localparam logic [NW-1:0] FRAMES_DONE = NW'(SETTLE_FRAMES);

  logic [FW-1:0] clk_in_frame;
  logic [NW-1:0] frames;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_in_frame <= '0;
      frames       <= '0;
    end else if (soft_rst) begin
      clk_in_frame <= '0;
      frames       <= '0;
    end else if (frames != FRAMES_DONE) begin
      if (clk_in_frame == FRAME_LAST) begin
        clk_in_frame <= '0;
        frames       <= frames + 1'b1;
      end else begin
        clk_in_frame <= clk_in_frame + 1'b1;
      end
    end
  end

  assign settled = frames == FRAMES_DONE;
endmodule

// File: rtl/sersync_slave.sv
module sersync_slave
  import sersync_pkg::*;
#(
  parameter int          TIMEOUT_CLKS  = 2000,
  parameter int          FRAME_CLKS    = 4000,
  parameter int          SETTLE_FRAMES = 3,
  parameter int          NUM_SCR       = 4,
  parameter int          SYNC_STAGES   = 2,
  parameter logic [7:0]  ID_VALUE      = 8'h5A,
  parameter logic [7:0]  CFG_RESET     = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       sdio_i,
  output logic       sdio_o,
  output logic       sdio_oe,
  output logic [7:0] cfg_o,
  output logic       soft_rst_o,
  output logic       settled_o
);
  logic              sclk_rise;
  logic              sclk_fall;
  logic              sdio_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              wr_valid;
  wr_req_t           wr_req;
  logic              soft_rst;
  logic              armed_w;
  logic [CNT_W-1:0]  bit_cnt_w;

  sersync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk_i),
    .sdio_i    (sdio_i),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdio_s    (sdio_s)
  );

  sersync_shifter #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdio_s    (sdio_s),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_valid  (wr_valid),
    .wr_req    (wr_req),
    .sdio_o    (sdio_o),
    .sdio_oe   (sdio_oe),
    .armed     (armed_w),
    .bit_cnt   (bit_cnt_w)
  );

  sersync_regfile #(
    .NUM_SCR   (NUM_SCR),
    .ID_VALUE  (ID_VALUE),
    .CFG_RESET (CFG_RESET)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_req   (wr_req),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cfg_o    (cfg_o),
    .soft_rst (soft_rst)
  );

  sersync_settle #(
    .FRAME_CLKS    (FRAME_CLKS),
    .SETTLE_FRAMES (SETTLE_FRAMES)
  ) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .settled  (settled_o)
  );

  assign soft_rst_o = soft_rst;
endmodule

// File: rtl/sersync_checker.sv
module sersync_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sdio_oe,
  input logic [7:0] cfg_o,
  input logic       soft_rst_o,
  input logic       settled_o,
  input logic       armed,
  input logic [3:0] bit_cnt
);
  // R6: the reset bit never stays up for a second cycle
  a_r6_cfg_top_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[7] |=> !cfg_o[7]);

  // R5: low configuration bits survive the soft reset they came with
  a_r5_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[7] |=> cfg_o[6:0] == $past(cfg_o[6:0]));

  // R9: soft reset pulls the settle flag low
  a_r9_settle_drops: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !settled_o);

  // R9: once settled, only a reset lowers the flag
  a_r9_settle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    settled_o && !soft_rst_o |=> settled_o);

  // R8: soft reset disarms the port and releases the line
  a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !armed && !sdio_oe);

  // R8: a disarmed port does not advance its bit counter
  a_r8_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> bit_cnt == 4'd0);

  // R3: the line is driven only in the data phase
  a_r3_oe_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> bit_cnt > 4'd7);
endmodule

bind sersync_slave sersync_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sdio_oe    (sdio_oe),
  .cfg_o      (cfg_o),
  .soft_rst_o (soft_rst_o),
  .settled_o  (settled_o),
  .armed      (armed_w),
  .bit_cnt    (bit_cnt_w)
);

// File: tb/sersync_slave_test.sv
module sersync_slave_test;
  localparam int TO    = 40;
  localparam int FR    = 60;
  localparam int SF    = 3;
  localparam int TOTAL = FR * SF;
  localparam int HP    = 5;
  localparam int NSCR  = 4;
  localparam logic [7:0] IDV = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic sdio_i = 1'b0;
  logic sdio_o, sdio_oe, soft_rst_o, settled_o;
  logic [7:0] cfg_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_soft = 0;
  int n_cfg7 = 0;

  logic [7:0] scr_m [NSCR];
  logic [7:0] cfg_m;

  always #4 clk = ~clk;

  sersync_slave #(
    .TIMEOUT_CLKS(TO), .FRAME_CLKS(FR), .SETTLE_FRAMES(SF),
    .NUM_SCR(NSCR), .ID_VALUE(IDV)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .cfg_o(cfg_o),
    .soft_rst_o(soft_rst_o), .settled_o(settled_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (soft_rst_o) n_soft++;
      if (cfg_o[7]) n_cfg7++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    if (a == 7'h00) return IDV;
    if (a == 7'h41) return cfg_m;
    if (a >= 7'h42 && a < 7'h42 + NSCR) return scr_m[a - 7'h42];
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NSCR; i++) scr_m[i] = 8'h00;
    cfg_m = 8'h00;
  endtask

  task automatic bit_io(input logic b, output logic got, output logic oe);
    sclk = 1'b0;
    sdio_i = b;
    repeat (HP) @(negedge clk);
    got = sdio_o;
    oe = sdio_oe;
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic xfer(input logic wr, input logic [6:0] a, input logic [7:0] d, input int pause,
                      output logic [7:0] rd, output int oe_data, output int oe_addr);
    logic g, o;
    oe_data = 0;
    oe_addr = 0;
    bit_io(wr, g, o);
    if (o) oe_addr++;
    for (int i = 6; i >= 0; i--) begin
      bit_io(a[i], g, o);
      if (o) oe_addr++;
    end
    repeat (pause) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      bit_io(wr ? d[i] : 1'b0, g, o);
      rd[i] = g;
      if (o) oe_data++;
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string req);
    logic [7:0] r;
    int od, oa;
    xfer(1'b1, a, d, 0, r, od, oa);
    check({req, " write keeps line released"}, od + oa, 0);
  endtask

  task automatic do_read(input logic [6:0] a, input string req);
    logic [7:0] r;
    int od, oa;
    xfer(1'b0, a, 8'h00, 0, r, od, oa);
    check({req, " read data"}, r, exp_rd(a));
    check({req, " R3 oe on all data bits only"}, {od[15:0], oa[15:0]}, {16'd8, 16'd0});
  endtask

  task automatic power_on();
    rst_n = 1'b0;
    sclk = 1'b1;
    sdio_i = 1'b0;
    repeat (5) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int od, oa, p0, c0;
    logic [7:0] v;

    // reset state
    repeat (4) @(negedge clk);
    check("R3 reset oe", sdio_oe, 0);
    check("R6 reset cfg", cfg_o, 8'h00);
    check("R6 reset pulse", soft_rst_o, 0);
    check("R9 reset settled", settled_o, 0);
    model_reset();
    rst_n = 1'b1;

    // R9: exact settle time after power-on
    repeat (TOTAL - 1) @(posedge clk);
    @(negedge clk);
    check("R9 settled one cycle early", settled_o, 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 settled on time", settled_o, 1);

    // R4 R1: sweep every address with reset contents
    for (int a = 0; a < 128; a++) do_read(7'(a), "R4 R1 sweep");

    // R2 R1: every data value through the scratch bank
    for (int k = 0; k < 256; k++) begin
      logic [6:0] ad;
      ad = 7'h42 + 7'(k % NSCR);
      v = 8'(k);
      do_write(ad, v, "R2");
      scr_m[k % NSCR] = v;
      do_read(ad, "R2 readback");
    end

    // R4: writes to identity and unmapped addresses change nothing
    do_write(7'h00, 8'hFF, "R4");
    do_write(7'h01, 8'h11, "R4");
    do_write(7'h40, 8'h44, "R4");
    do_write(7'h42 + 7'(NSCR), 8'h22, "R4");
    do_write(7'h7F, 8'h33, "R4");
    for (int a = 0; a < 128; a++) do_read(7'(a), "R4 after stray writes");

    // R2 R6: configuration writes without the reset bit
    p0 = n_soft;
    for (int k = 0; k < 5; k++) begin
      v = 8'((k * 8'h2B + 8'h15) & 8'h7F);
      do_write(7'h41, v, "R2 cfg");
      cfg_m = v;
      check("R2 cfg_o", cfg_o, v);
      do_read(7'h41, "R2 cfg readback");
    end
    check("R6 no pulse without bit 7", n_soft, p0);

    // R7: short pause inside a transaction keeps alignment
    xfer(1'b1, 7'h43, 8'hC3, TO / 2, r, od, oa);
    scr_m[1] = 8'hC3;
    do_read(7'h43, "R7 short pause");

    // R7: stray bits, then idle gap realigns
    begin
      logic g, o;
      for (int i = 0; i < 3; i++) bit_io(1'b1, g, o);
      repeat (TO + 5) @(negedge clk);
      do_read(7'h43, "R7 realigned after idle");
      // misaligned write lands on unmapped 0x78, then idle gap recovers
      for (int i = 0; i < 3; i++) bit_io(1'b1, g, o);
      xfer(1'b1, 7'h44, 8'h5A, 0, r, od, oa);
      repeat (TO + 5) @(negedge clk);
      for (int i = 0; i < NSCR; i++) do_read(7'h42 + 7'(i), "R7 misaligned write harmless");
    end

    // R5 R6 R8 R9: soft reset with low bits set
    p0 = n_soft;
    c0 = n_cfg7;
    do_write(7'h41, 8'h85, "R5");
    model_reset();
    cfg_m = 8'h05;
    check("R5 low bits kept", cfg_o, 8'h05);
    check("R6 one pulse", n_soft - p0, 1);
    check("R6 bit 7 high one cycle", n_cfg7 - c0, 1);
    check("R9 settled low after soft reset", settled_o, 0);
    xfer(1'b0, 7'h42, 8'h00, 0, r, od, oa);
    check("R8 unarmed after soft reset no drive", od + oa, 0);
    repeat (TO + 5) @(negedge clk);
    for (int i = 0; i < NSCR; i++) do_read(7'h42 + 7'(i), "R5 scratch cleared");
    do_read(7'h41, "R5 cfg readback");
    repeat (TOTAL) @(negedge clk);
    check("R9 settled after soft reset", settled_o, 1);

    // R8: edges straight after power-on are ignored
    power_on();
    xfer(1'b1, 7'h42, 8'hAA, 0, r, od, oa);
    check("R8 unarmed write no drive", od + oa, 0);
    repeat (TO + 5) @(negedge clk);
    do_read(7'h42, "R8 write before timer ignored");
    do_read(7'h41, "R8 cfg at power-on value");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule